// File: doc/BRIEF.md
# Tagged Link Frame Encoder

This block is the transmit half of a narrow chip-to-chip link between a board-level bus expander and a core device. Bus events arrive from the expander side on three independent valid/ready request channels: an address phase, a write-data phase and an auxiliary status update. Each request becomes a burst of 16-bit words, sent one word per clock with no gaps inside a burst.

The first word of every burst is a header. Its upper byte is a tag that names the burst type, and its lower byte holds type-specific control bits. A frame strobe marks the header word only, and the receiver takes the payload words on the clocks that follow. The number of payload words depends on the tag: two for an address, one word per 16 data bits for write data, and none for an auxiliary update. When requests compete, a fixed priority picks the winner. A burst in flight is never interrupted, and the next burst can start on the clock right after the last payload word.

Top module: `link_frame_tx`

## Requirements
- R1: With no burst in progress and no request granted, `link_frame` is 0, `link_word` is 0x0000 and every ready output is 0.
- R2: An address burst is three words. The header is 0xA0 in bits 15:8, the address modifier in bits 7:2, 0 in bit 1 and the active-low long-word flag in bit 0. The next word is address bits 31:16. The last word is address bits 15:1 in word bits 15:1, with word bit 0 at 0.
- R3: A write-data burst is a header followed by DATA_W/16 words. The header is 0xA2 in bits 15:8, zeros in bits 7:2 and the two active-low data strobes in bits 1:0. The payload words carry the data value, most significant 16 bits first.
- R4: An auxiliary burst is one word. It holds 0xA7 in bits 15:8, the active-low IACKIN flag in bit 7, the active-low IACK flag in bit 6 and the 6-bit geographical address in bits 5:0.
- R5: `link_frame` is 1 on every header word and 0 on every payload word.
- R6: A channel's ready output is 1 for exactly one cycle per burst, in the cycle its header is on `link_word`. The payload is captured in that cycle, so later changes to the request inputs do not alter the words sent.
- R7: When requests are pending together, the auxiliary channel wins over address, and address wins over write data.
- R8: While payload words remain to be sent, no ready output rises. A request pending during a burst gets its header in the cycle right after the last payload word.
- R9: A synchronous active-low reset (`rst_n`) forces `link_frame`, `link_word` and all ready outputs to 0 in the reset cycle. It abandons any burst that is partly sent, so after reset is released the link is idle until a new request arrives.
- R10: A header never carries any tag other than 0xA0, 0xA2 or 0xA7 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aux_valid | input | 1 | Auxiliary update request |
| aux_ready | output | 1 | Auxiliary request accepted (header cycle) |
| aux_ga | input | 6 | Geographical address |
| aux_iack_n | input | 1 | Active-low IACK flag |
| aux_iackin_n | input | 1 | Active-low IACKIN flag |
| adr_valid | input | 1 | Address phase request |
| adr_ready | output | 1 | Address request accepted (header cycle) |
| adr_am | input | 6 | Address modifier |
| adr_lword_n | input | 1 | Active-low long-word flag |
| adr_addr | input | 31 | Address bits 31:1 |
| wr_valid | input | 1 | Write-data request |
| wr_ready | output | 1 | Write request accepted (header cycle) |
| wr_ds_n | input | 2 | Active-low data strobes |
| wr_data | input | DATA_W | Write data value |
| link_word | output | 16 | Link data word |
| link_frame | output | 1 | Header strobe |

## Verification
The bench uses the default DATA_W of 64, so a write burst is four payload words. That makes it the longest burst, and it gives the widest window for the no-preemption and mid-burst reset cases. In that configuration the payload store is four words deep. Both the two-word address payload and the four-word data payload are exercised, so the length selection and the most-significant-first ordering are both observable at the link.

// File: rtl/link_frame_pkg.sv
package link_frame_pkg;
  localparam int WORD_W = 16;
  localparam int TAG_W  = 8;

  localparam logic [TAG_W-1:0] TAG_ADDR  = 8'hA0;
  localparam logic [TAG_W-1:0] TAG_WDATA = 8'hA2;
  localparam logic [TAG_W-1:0] TAG_AUX   = 8'hA7;

  // channel index doubles as priority rank (0 = highest)
  localparam int CH_AUX   = 0;
  localparam int CH_ADDR  = 1;
  localparam int CH_WDATA = 2;
  localparam int N_CH     = 3;

  function automatic logic [WORD_W-1:0] hdr_addr(input logic [5:0] am, input logic lword_n);
    return {TAG_ADDR, am, 1'b0, lword_n};
  endfunction

  function automatic logic [WORD_W-1:0] hdr_wdata(input logic [1:0] ds_n);
    return {TAG_WDATA, 6'b000000, ds_n};
  endfunction

  function automatic logic [WORD_W-1:0] hdr_aux(input logic [5:0] ga, input logic iack_n,
                                                input logic iackin_n);
    return {TAG_AUX, iackin_n, iack_n, ga};
  endfunction

  // address bits 31:1 split into the two payload words
  function automatic logic [WORD_W-1:0] addr_hi(input logic [30:0] a);
    return a[30:15];
  endfunction

  function automatic logic [WORD_W-1:0] addr_lo(input logic [30:0] a);
    return {a[14:0], 1'b0};
  endfunction
endpackage

// File: rtl/lft_arbiter.sv
module lft_arbiter #(
  parameter int N = 3
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // index 0 has the highest priority
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (en && req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lft_payload_shift.sv
module lft_payload_shift #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        load_len,
  input  logic [DEPTH*WORD_W-1:0] load_words,  // word i at [i*WORD_W +: WORD_W], sent first at i=0
  output logic                    busy,
  output logic [WORD_W-1:0]       head
);
  logic [WORD_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left <= '0;
    else if (load)
      left <= load_len;
    else if (left != '0)
      left <= left - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load)
        slot[i] <= load_words[i*WORD_W +: WORD_W];
      else if (i < DEPTH - 1)
        slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
    end
  end

  assign busy = (left != '0);
  assign head = slot[0];
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
  import link_frame_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_valid,
  output logic              aux_ready,
  input  logic [5:0]        aux_ga,
  input  logic              aux_iack_n,
  input  logic              aux_iackin_n,
  input  logic              adr_valid,
  output logic              adr_ready,
  input  logic [5:0]        adr_am,
  input  logic              adr_lword_n,
  input  logic [30:0]       adr_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_ds_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [15:0]       link_word,
  output logic              link_frame
);
  localparam int DATA_WORDS = DATA_W / WORD_W;
  localparam int PAY_DEPTH  = (DATA_WORDS > 2) ? DATA_WORDS : 2;
  localparam int CNT_W      = $clog2(PAY_DEPTH + 1);

  logic [N_CH-1:0]           req, gnt;
  logic                      pay_busy;
  logic                      grant_any;
  logic [WORD_W-1:0]         pay_head;
  logic [WORD_W-1:0]         hdr_word;
  logic                      pay_load;
  logic [CNT_W-1:0]          pay_len;
  logic [PAY_DEPTH*WORD_W-1:0] pay_words;
  logic [PAY_DEPTH*WORD_W-1:0] addr_words;
  logic [PAY_DEPTH*WORD_W-1:0] data_words;

  assign req[CH_AUX]   = aux_valid;
  assign req[CH_ADDR]  = adr_valid;
  assign req[CH_WDATA] = wr_valid;

  lft_arbiter #(.N(N_CH)) u_arb (
    .en  (rst_n && !pay_busy),
    .req (req),
    .gnt (gnt)
  );

  assign grant_any = |gnt;
  assign aux_ready = gnt[CH_AUX];
  assign adr_ready = gnt[CH_ADDR];
  assign wr_ready  = gnt[CH_WDATA];

  always_comb begin
    hdr_word = '0;
    if (gnt[CH_AUX])        hdr_word = hdr_aux(aux_ga, aux_iack_n, aux_iackin_n);
    else if (gnt[CH_ADDR])  hdr_word = hdr_addr(adr_am, adr_lword_n);
    else if (gnt[CH_WDATA]) hdr_word = hdr_wdata(wr_ds_n);
  end

  // payload images, first word to send in slot 0
  always_comb begin
    addr_words = '0;
    addr_words[0 +: WORD_W]      = addr_hi(adr_addr);
    addr_words[WORD_W +: WORD_W] = addr_lo(adr_addr);
  end

  for (genvar i = 0; i < PAY_DEPTH; i++) begin : g_data
    if (i < DATA_WORDS) begin : g_used
      assign data_words[i*WORD_W +: WORD_W] = wr_data[DATA_W-1-i*WORD_W -: WORD_W];
    end else begin : g_pad
      assign data_words[i*WORD_W +: WORD_W] = '0;
    end
  end

  assign pay_load  = gnt[CH_ADDR] | gnt[CH_WDATA];
  assign pay_words = gnt[CH_ADDR] ? addr_words : data_words;
  assign pay_len   = gnt[CH_ADDR] ? CNT_W'(2) : CNT_W'(DATA_WORDS);

  lft_payload_shift #(.WORD_W(WORD_W), .DEPTH(PAY_DEPTH)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (pay_load),
    .load_len   (pay_len),
    .load_words (pay_words),
    .busy       (pay_busy),
    .head       (pay_head)
  );

  assign link_frame = grant_any;
  assign link_word  = (rst_n && pay_busy) ? pay_head : hdr_word;
endmodule

// File: rtl/lft_checker.sv
module lft_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        aux_valid,
  input logic        aux_ready,
  input logic        adr_ready,
  input logic        wr_ready,
  input logic [15:0] link_word,
  input logic        link_frame,
  input logic        pay_busy
);
  a_r6_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aux_ready, adr_ready, wr_ready}));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!pay_busy && !link_frame) |-> (link_word == 16'h0000));

  a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pay_busy |-> !(aux_ready || adr_ready || wr_ready));

  a_r10_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    link_frame |-> (link_word[15:8] == 8'hA0 || link_word[15:8] == 8'hA2 ||
                    link_word[15:8] == 8'hA7));

  a_r5_addr_payload_follows: assert property (@(posedge clk) disable iff (!rst_n)
    adr_ready |=> (!link_frame && pay_busy));

  a_r3_wdata_payload_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> (!link_frame && pay_busy));

  a_r7_aux_first: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_valid && !pay_busy) |-> aux_ready);
endmodule

bind link_frame_tx lft_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .aux_valid  (aux_valid),
  .aux_ready  (aux_ready),
  .adr_ready  (adr_ready),
  .wr_ready   (wr_ready),
  .link_word  (link_word),
  .link_frame (link_frame),
  .pay_busy   (pay_busy)
);

// File: tb/tb_link_frame_tx.sv
module tb_link_frame_tx;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_valid = 0, aux_iack_n = 1, aux_iackin_n = 1;
  logic [5:0] aux_ga = '0;
  logic adr_valid = 0, adr_lword_n = 1;
  logic [5:0] adr_am = '0;
  logic [30:0] adr_addr = '0;
  logic wr_valid = 0;
  logic [1:0] wr_ds_n = 2'b11;
  logic [DATA_W-1:0] wr_data = '0;
  logic aux_ready, adr_ready, wr_ready;
  logic [15:0] link_word;
  logic link_frame;

  int checks = 0;
  int fails = 0;

  typedef struct { logic f; logic [15:0] w; string r; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  link_frame_tx #(.DATA_W(DATA_W)) dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic void push(input logic f, input logic [15:0] w, input string r);
    exp_t e;
    e.f = f; e.w = w; e.r = r;
    exp_q.push_back(e);
  endfunction

  function automatic void exp_aux(input logic [5:0] ga, input logic iack_n, input logic iackin_n, input string r);
    push(1'b1, 16'hA700 | (16'(iackin_n) << 7) | (16'(iack_n) << 6) | 16'(ga), r);
  endfunction

  function automatic void exp_addr(input logic [5:0] am, input logic lw, input logic [31:0] a, input string r);
    push(1'b1, 16'hA000 | (16'(am) << 2) | 16'(lw), r);
    push(1'b0, a[31:16], r);
    push(1'b0, a[15:0] & 16'hFFFE, r);
  endfunction

  function automatic void exp_wr(input logic [1:0] ds, input logic [DATA_W-1:0] d, input string r);
    push(1'b1, 16'hA200 | 16'(ds), r);
    for (int i = DATA_W / 16 - 1; i >= 0; i--) push(1'b0, d[i*16 +: 16], r);
  endfunction

  function automatic int len_of(input logic [7:0] tag);
    if (tag == 8'hA0) return 2;
    if (tag == 8'hA2) return DATA_W / 16;
    return 0;
  endfunction

  // scoreboard monitor
  int rem = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check(!link_frame && link_word == 16'h0, "R9", {15'b0, link_frame, link_word}, 32'h0);
      rem = 0;
    end else if (rem > 0 || link_frame) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", {15'b0, link_frame, link_word}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(link_frame == e.f && link_word == e.w, e.r,
              {15'b0, link_frame, link_word}, {15'b0, e.f, e.w});
      end
      if (rem > 0) rem--;
      else begin
        check(link_word[15:8] == 8'hA0 || link_word[15:8] == 8'hA2 || link_word[15:8] == 8'hA7,
              "R10", {24'b0, link_word[15:8]}, 32'hA0);
        rem = len_of(link_word[15:8]);
      end
    end else begin
      check(link_word == 16'h0 && !aux_ready && !adr_ready && !wr_ready, "R1",
            {13'b0, aux_ready, adr_ready, wr_ready, link_word}, 32'h0);
    end
  end

  task automatic drive_aux(input logic [5:0] ga, input logic ik, input logic ikin);
    @(posedge clk); #1;
    aux_ga = ga; aux_iack_n = ik; aux_iackin_n = ikin; aux_valid = 1;
    do @(negedge clk); while (!aux_ready);
    @(posedge clk); #1;
    aux_valid = 0; aux_ga = ~ga; aux_iack_n = ~ik; aux_iackin_n = ~ikin;
  endtask

  task automatic drive_addr(input logic [5:0] am, input logic lw, input logic [31:0] a);
    @(posedge clk); #1;
    adr_am = am; adr_lword_n = lw; adr_addr = a[31:1]; adr_valid = 1;
    do @(negedge clk); while (!adr_ready);
    @(posedge clk); #1;
    adr_am = ~am; adr_lword_n = ~lw; adr_addr = ~a[31:1];  // R6: capture test
    @(negedge clk);
    check(!adr_ready, "R6", {31'b0, adr_ready}, 32'h0);
    @(posedge clk); #1;
    adr_valid = 0;
  endtask

  task automatic drive_wr(input logic [1:0] ds, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    wr_ds_n = ds; wr_data = d; wr_valid = 1;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_ds_n = ~ds; wr_data = ~d;  // R6: capture test
    @(negedge clk);
    check(!wr_ready, "R6", {31'b0, wr_ready}, 32'h0);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9/R1: requests ignored during reset
    #1 aux_valid = 1; adr_valid = 1;
    repeat (2) @(negedge clk);
    check(!aux_ready && !adr_ready && !link_frame && link_word == 0, "R9",
          {14'b0, aux_ready, adr_ready, link_word}, 32'h0);
    @(posedge clk); #1;
    aux_valid = 0; adr_valid = 0;
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R2 address burst
    exp_addr(6'h39, 1'b1, 32'hDEAD_BEEF, "R2");
    drive_addr(6'h39, 1'b1, 32'hDEAD_BEEF);
    exp_addr(6'h0D, 1'b0, 32'h0001_8002, "R2");
    drive_addr(6'h0D, 1'b0, 32'h0001_8002);

    // R3 write burst
    exp_wr(2'b01, 64'h0123_4567_89AB_CDEF, "R3");
    drive_wr(2'b01, 64'h0123_4567_89AB_CDEF);
    exp_wr(2'b10, 64'hF00D_1111_2222_8001, "R3");
    drive_wr(2'b10, 64'hF00D_1111_2222_8001);

    // R4 aux bit positions
    exp_aux(6'h2A, 1'b0, 1'b1, "R4");
    drive_aux(6'h2A, 1'b0, 1'b1);
    exp_aux(6'h15, 1'b1, 1'b0, "R4");
    drive_aux(6'h15, 1'b1, 1'b0);
    repeat (2) @(posedge clk);

    // R7 all three at once: aux, then address, then write
    exp_aux(6'h03, 1'b1, 1'b1, "R7");
    exp_addr(6'h3F, 1'b0, 32'h8000_0004, "R7");
    exp_wr(2'b00, 64'hAAAA_5555_1234_4321, "R7");
    fork
      drive_aux(6'h03, 1'b1, 1'b1);
      drive_addr(6'h3F, 1'b0, 32'h8000_0004);
      drive_wr(2'b00, 64'hAAAA_5555_1234_4321);
    join
    repeat (2) @(posedge clk);

    // R7 address beats write
    exp_addr(6'h09, 1'b1, 32'h7777_0000, "R7");
    exp_wr(2'b11, 64'h0102_0304_0506_0708, "R7");
    fork
      drive_wr(2'b11, 64'h0102_0304_0506_0708);
      drive_addr(6'h09, 1'b1, 32'h7777_0000);
    join
    repeat (2) @(posedge clk);

    // R8 aux arriving during write payload waits, then follows with no gap
    exp_wr(2'b01, 64'h1357_9BDF_2468_ACE0, "R8");
    exp_aux(6'h3C, 1'b0, 1'b0, "R8");
    fork
      drive_wr(2'b01, 64'h1357_9BDF_2468_ACE0);
      begin
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
        aux_ga = 6'h3C; aux_iack_n = 0; aux_iackin_n = 0; aux_valid = 1;
        for (int i = 0; i < DATA_W / 16; i++) begin
          @(negedge clk);
          check(!aux_ready, "R8", {31'b0, aux_ready}, 32'h0);
        end
        @(negedge clk);
        check(aux_ready && link_frame, "R8", {30'b0, aux_ready, link_frame}, 32'h3);
        @(posedge clk); #1 aux_valid = 0;
      end
    join
    repeat (2) @(posedge clk);

    // R9 reset in the middle of a write burst
    exp_wr(2'b10, 64'h5A5A_A5A5_C3C3_3C3C, "R9");
    @(posedge clk); #1;
    wr_ds_n = 2'b10; wr_data = 64'h5A5A_A5A5_C3C3_3C3C; wr_valid = 1;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1 wr_valid = 0;
    @(negedge clk);
    @(posedge clk); #1 rst_n = 0;
    @(negedge clk);
    check(!link_frame && link_word == 0 && !wr_ready, "R9", {15'b0, link_frame, link_word}, 32'h0);
    @(posedge clk); #1 rst_n = 1;
    exp_q.delete();
    @(negedge clk);
    check(!link_frame && link_word == 0, "R9", {15'b0, link_frame, link_word}, 32'h0);
    repeat (3) @(posedge clk);

    // R2 after reset, link works again
    exp_addr(6'h11, 1'b0, 32'h0F0F_F0F0, "R2");
    drive_addr(6'h11, 1'b0, 32'h0F0F_F0F0);
    repeat (4) @(posedge clk);

    check(exp_q.size() == 0, "R5", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule